// File: doc/BRIEF.md
# Multithreaded Request Injector and Step Sequencer

This block is the processor-side engine of a shared-memory emulator built on a tree network. One physical network port serves a fixed number of lightweight virtual threads, and each thread owns a register. In every emulated step the block visits the threads in ascending index order, one per cycle. For each thread, it samples that thread's memory-reference descriptor from the thread logic through a lookup port, and it turns every descriptor that references shared memory into one request packet. The packet carries the access type, the issuing thread, the destination module, the local address and the write data. After the last thread it emits a single end-of-stream marker.

Replies come back on a reply port that is always ready. A data reply is written into the register of the thread named in the reply. An end-of-replies marker returns one step credit. The block needs no global barrier. A new step may begin as soon as the previous end-of-stream has left, but no more than two steps can be open at once. Every packet carries a one-bit step tag, so the packets of two open steps can always be told apart. The thread arithmetic, the address hash and the network itself are outside the block.

Top module: `vp_injector`

## Requirements
- R1: After reset `pkt_valid` is 0, `rsp_ready` is 1 and every thread register reads 0 through `rd_sel`/`rd_data`.
- R2: In each step the threads are visited in ascending index order. A thread with `thr_ref`=1 yields exactly one packet with `pkt_kind` 0 (read, `thr_wr`=0) or 1 (write, `thr_wr`=1), `pkt_thread` equal to its index, and `pkt_mod`/`pkt_addr` taken from its descriptor. `pkt_data` carries the write data for a write and is 0 for a read.
- R3: A thread with `thr_ref`=0 yields no packet. Each step ends with exactly one end-of-stream packet (`pkt_kind` 2, all other fields 0) after its last request, and this holds even for a step with no requests.
- R4: `pkt_step` is 0 for the first step after reset. It is the same for every packet of a step, including the step's end-of-stream, and it toggles from one step to the next.
- R5: No more than two steps are open at a time. A step is open from its end-of-stream until an end-of-replies reply (`rsp_valid`=1, `rsp_eor`=1) returns its credit. With two steps open, no new step starts until such a reply arrives.
- R6: A data reply (`rsp_valid`=1, `rsp_eor`=0) writes `rsp_data` into the register of thread `rsp_thread`, and the new value is readable on the next cycle.
- R7: An end-of-replies reply writes no thread register.
- R8: `rsp_ready` is 1 in every cycle after reset, so replies are never held back.
- R9: A step starts only from idle while `run` is 1. Once started, a step runs to its end-of-stream even if `run` falls, and no step starts while `run` is 0.
- R10: An end-of-replies reply that arrives while no step is open is ignored and gives no extra credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Permission to start a new step |
| thr_sel | output | THR_W | Thread whose descriptor is being looked up |
| thr_ref | input | 1 | Selected thread references shared memory this step |
| thr_wr | input | 1 | Reference is a write (1) or a read (0) |
| thr_mod | input | MOD_W | Destination memory module |
| thr_addr | input | ADDR_W | Local address inside the module |
| thr_wdata | input | DATA_W | Write data |
| pkt_valid | output | 1 | A packet is presented to the network this cycle |
| pkt_kind | output | 2 | 0 read, 1 write, 2 end-of-stream |
| pkt_thread | output | THR_W | Issuing thread (origin) |
| pkt_mod | output | MOD_W | Destination module (target) |
| pkt_addr | output | ADDR_W | Local address |
| pkt_data | output | DATA_W | Write data, 0 otherwise |
| pkt_step | output | 1 | Step tag |
| rsp_valid | input | 1 | A reply is present |
| rsp_eor | input | 1 | Reply is an end-of-replies marker |
| rsp_thread | input | THR_W | Thread the reply belongs to |
| rsp_data | input | DATA_W | Read data |
| rsp_ready | output | 1 | Reply acceptance, always 1 |
| rd_sel | input | THR_W | Thread register read select |
| rd_data | output | DATA_W | Selected thread register |

## Verification
The bench targets several corner cases. One is the step with no references at all: a design that skips its end-of-stream would leave the network waiting forever. Another is the third step requested while two are open: a design with a loose credit bound would inject it early, and one with a tight bound would stall with only one step open. A stray end-of-replies arriving at reset time is another case: a counter that wraps on it would either never start a step or would allow too many. The bench also checks that end-of-replies markers leave the thread registers alone, that the step tag flips exactly at step boundaries, and that a one-cycle `run` pulse still completes the whole step.

// File: rtl/vp_inj_pkg.sv
`timescale 1ns/1ps
package vp_inj_pkg;
  typedef enum logic [1:0] {
    PK_READ  = 2'd0,
    PK_WRITE = 2'd1,
    PK_EOS   = 2'd2
  } pkt_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WALK = 2'd1,
    SQ_MARK = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vp_inj_seq.sv
`timescale 1ns/1ps
module vp_inj_seq
  import vp_inj_pkg::*;
#(
  parameter int NTHR   = 4,
  parameter int MOD_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int THR_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  output logic [THR_W-1:0]  thr_sel,
  input  logic              thr_ref,
  input  logic              thr_wr,
  input  logic [MOD_W-1:0]  thr_mod,
  input  logic [ADDR_W-1:0] thr_addr,
  input  logic [DATA_W-1:0] thr_wdata,
  output logic              pkt_valid,
  output logic [1:0]        pkt_kind,
  output logic [THR_W-1:0]  pkt_thread,
  output logic [MOD_W-1:0]  pkt_mod,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_step,
  output logic              eos_fire,
  output logic              idle
);
  localparam logic [THR_W-1:0] LAST = THR_W'(NTHR - 1);

  seq_state_e        state_q, state_d;
  logic [THR_W-1:0]  cur_q, cur_d;
  logic              cur_en;
  logic              phase_q, phase_d;
  logic              pv_q, pv_d;
  logic              ld_en;
  pkt_kind_e         pk_q, pk_d;
  logic [THR_W-1:0]  pt_q, pt_d;
  logic [MOD_W-1:0]  pm_q, pm_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              ps_q, ps_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cur_en  = 1'b0;
    phase_d = phase_q;
    pv_d    = 1'b0;
    ld_en   = 1'b0;
    pk_d    = pk_q;
    pt_d    = pt_q;
    pm_d    = pm_q;
    pa_d    = pa_q;
    pd_d    = pd_q;
    ps_d    = ps_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_ok) begin
          state_d = SQ_WALK;
          cur_d   = '0;
          cur_en  = 1'b1;
        end
      end
      SQ_WALK: begin
        if (thr_ref) begin
          pv_d  = 1'b1;
          ld_en = 1'b1;
          pk_d  = thr_wr ? PK_WRITE : PK_READ;
          pt_d  = cur_q;
          pm_d  = thr_mod;
          pa_d  = thr_addr;
          pd_d  = thr_wr ? thr_wdata : '0;
          ps_d  = phase_q;
        end
        if (cur_q == LAST) begin
          state_d = SQ_MARK;
        end else begin
          cur_d  = cur_q + THR_W'(1);
          cur_en = 1'b1;
        end
      end
      SQ_MARK: begin
        pv_d    = 1'b1;
        ld_en   = 1'b1;
        pk_d    = PK_EOS;
        pt_d    = '0;
        pm_d    = '0;
        pa_d    = '0;
        pd_d    = '0;
        ps_d    = phase_q;
        phase_d = ~phase_q;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
      phase_q <= 1'b0;
      pv_q    <= 1'b0;
      pk_q    <= PK_READ;
      pt_q    <= '0;
      pm_q    <= '0;
      pa_q    <= '0;
      pd_q    <= '0;
      ps_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      pv_q    <= pv_d;
      if (cur_en) cur_q <= cur_d;
      if (ld_en) begin
        pk_q <= pk_d;
        pt_q <= pt_d;
        pm_q <= pm_d;
        pa_q <= pa_d;
        pd_q <= pd_d;
        ps_q <= ps_d;
      end
    end
  end

  assign thr_sel    = cur_q;
  assign pkt_valid  = pv_q;
  assign pkt_kind   = pk_q;
  assign pkt_thread = pt_q;
  assign pkt_mod    = pm_q;
  assign pkt_addr   = pa_q;
  assign pkt_data   = pd_q;
  assign pkt_step   = ps_q;
  assign eos_fire   = (state_q == SQ_MARK);
  assign idle       = (state_q == SQ_IDLE);
endmodule

// File: rtl/vp_inj_credit.sv
`timescale 1ns/1ps
module vp_inj_credit #(
  parameter int MAX_INFLIGHT = 2,
  localparam int CW = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic eor,
  output logic room
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dec;

  always_comb begin
    dec   = eor && (cnt_q != '0);
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + CW'(1);
    else if (!inc && dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign room = (cnt_q < CW'(MAX_INFLIGHT));
endmodule

// File: rtl/vp_inj_rf.sv
`timescale 1ns/1ps
module vp_inj_rf #(
  parameter int NTHR   = 4,
  parameter int DATA_W = 16,
  localparam int THR_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [THR_W-1:0]             wsel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NTHR-1:0][DATA_W-1:0]  regs_o
);
  logic [NTHR-1:0] hit;

  for (genvar g = 0; g < NTHR; g++) begin : g_hit
    assign hit[g] = we && (wsel == THR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_o <= '0;
    end else begin
      for (int i = 0; i < NTHR; i++) begin
        if (hit[i]) regs_o[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/vp_injector.sv
`timescale 1ns/1ps
module vp_injector #(
  parameter int NTHR         = 4,
  parameter int MOD_W        = 3,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int MAX_INFLIGHT = 2,
  localparam int THR_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [THR_W-1:0]  thr_sel,
  input  logic              thr_ref,
  input  logic              thr_wr,
  input  logic [MOD_W-1:0]  thr_mod,
  input  logic [ADDR_W-1:0] thr_addr,
  input  logic [DATA_W-1:0] thr_wdata,
  output logic              pkt_valid,
  output logic [1:0]        pkt_kind,
  output logic [THR_W-1:0]  pkt_thread,
  output logic [MOD_W-1:0]  pkt_mod,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_step,
  input  logic              rsp_valid,
  input  logic              rsp_eor,
  input  logic [THR_W-1:0]  rsp_thread,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  input  logic [THR_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rs_q;
  logic       rst_s;
  logic       room, eos_fire, seq_idle;
  logic [NTHR-1:0][DATA_W-1:0] rf_regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  vp_inj_seq #(
    .NTHR(NTHR), .MOD_W(MOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .start_ok(run && room),
    .thr_sel(thr_sel), .thr_ref(thr_ref), .thr_wr(thr_wr),
    .thr_mod(thr_mod), .thr_addr(thr_addr), .thr_wdata(thr_wdata),
    .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .pkt_thread(pkt_thread),
    .pkt_mod(pkt_mod), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .pkt_step(pkt_step), .eos_fire(eos_fire), .idle(seq_idle)
  );

  vp_inj_credit #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_credit (
    .clk(clk), .rst_n(rst_s), .inc(eos_fire),
    .eor(rsp_valid && rsp_eor), .room(room)
  );

  vp_inj_rf #(.NTHR(NTHR), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_s), .we(rsp_valid && !rsp_eor),
    .wsel(rsp_thread), .wdata(rsp_data), .regs_o(rf_regs)
  );

  assign rsp_ready = 1'b1;
  assign rd_data   = rf_regs[rd_sel];
endmodule

// File: rtl/vp_injector_chk.sv
`timescale 1ns/1ps
module vp_injector_chk #(
  parameter int NTHR         = 4,
  parameter int MOD_W        = 3,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int MAX_INFLIGHT = 2,
  localparam int THR_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                        clk,
  input logic                        rst_s,
  input logic                        run,
  input logic                        seq_idle,
  input logic [THR_W-1:0]            thr_sel,
  input logic [MOD_W-1:0]            thr_mod,
  input logic [ADDR_W-1:0]           thr_addr,
  input logic                        pkt_valid,
  input logic [1:0]                  pkt_kind,
  input logic [THR_W-1:0]            pkt_thread,
  input logic [MOD_W-1:0]            pkt_mod,
  input logic [ADDR_W-1:0]           pkt_addr,
  input logic                        pkt_step,
  input logic                        rsp_valid,
  input logic                        rsp_eor,
  input logic [THR_W-1:0]            rsp_thread,
  input logic [DATA_W-1:0]           rsp_data,
  input logic [NTHR-1:0][DATA_W-1:0] rf_regs
);
  localparam int OW = $clog2(MAX_INFLIGHT + 2);
  logic          seen_q, last_step_q, last_eos_q;
  logic [OW-1:0] open_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      seen_q      <= 1'b0;
      last_step_q <= 1'b0;
      last_eos_q  <= 1'b0;
      open_q      <= '0;
    end else begin
      if (pkt_valid) begin
        seen_q      <= 1'b1;
        last_step_q <= pkt_step;
        last_eos_q  <= (pkt_kind == 2'd2);
      end
      if ((pkt_valid && pkt_kind == 2'd2) && !(rsp_valid && rsp_eor && open_q != '0))
        open_q <= open_q + OW'(1);
      else if (!(pkt_valid && pkt_kind == 2'd2) && rsp_valid && rsp_eor && open_q != '0)
        open_q <= open_q - OW'(1);
    end
  end

  // R2
  req_fields_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pkt_valid && pkt_kind != 2'd2) |->
      (pkt_thread == $past(thr_sel) && pkt_mod == $past(thr_mod) && pkt_addr == $past(thr_addr)));

  // R3
  eos_after_last_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pkt_valid && pkt_kind == 2'd2) |-> ($past(thr_sel) == THR_W'(NTHR - 1)));

  // R4
  step_first_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pkt_valid && !seen_q) |-> !pkt_step);

  // R4
  step_same_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pkt_valid && seen_q && !last_eos_q) |-> (pkt_step == last_step_q));

  // R4
  step_flip_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (pkt_valid && seen_q && last_eos_q) |-> (pkt_step != last_step_q));

  // R5
  open_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
    open_q <= OW'(MAX_INFLIGHT));

  // R6
  reply_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rsp_valid && !rsp_eor) |=> (rf_regs[$past(rsp_thread)] == $past(rsp_data)));

  // R7
  eor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rsp_valid && rsp_eor) |=> $stable(rf_regs));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (seq_idle && !run) |=> seq_idle);
endmodule

bind vp_injector vp_injector_chk #(
  .NTHR(NTHR), .MOD_W(MOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_INFLIGHT(MAX_INFLIGHT)
) u_chk (
  .clk(clk), .rst_s(rst_s), .run(run), .seq_idle(seq_idle),
  .thr_sel(thr_sel), .thr_mod(thr_mod), .thr_addr(thr_addr),
  .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .pkt_thread(pkt_thread),
  .pkt_mod(pkt_mod), .pkt_addr(pkt_addr), .pkt_step(pkt_step),
  .rsp_valid(rsp_valid), .rsp_eor(rsp_eor), .rsp_thread(rsp_thread),
  .rsp_data(rsp_data), .rf_regs(rf_regs)
);

// File: tb/vp_injector_tb.sv
`timescale 1ns/1ps
module vp_injector_tb;
  localparam int NT = 4, MW = 3, AW = 8, DW = 16, TW = 2;
  localparam int PW = 2 + TW + MW + AW + DW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [TW-1:0] thr_sel;
  logic thr_ref, thr_wr;
  logic [MW-1:0] thr_mod;
  logic [AW-1:0] thr_addr;
  logic [DW-1:0] thr_wdata;
  logic pkt_valid, pkt_step, rsp_ready;
  logic [1:0] pkt_kind;
  logic [TW-1:0] pkt_thread;
  logic [MW-1:0] pkt_mod;
  logic [AW-1:0] pkt_addr;
  logic [DW-1:0] pkt_data;
  logic rsp_valid = 1'b0, rsp_eor = 1'b0;
  logic [TW-1:0] rsp_thread = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [TW-1:0] rd_sel = '0;
  logic [DW-1:0] rd_data;

  logic          d_ref [NT];
  logic          d_wr  [NT];
  logic [MW-1:0] d_mod [NT];
  logic [AW-1:0] d_addr[NT];
  logic [DW-1:0] d_wd  [NT];
  logic [DW-1:0] exp_reg[NT];
  logic [PW-1:0] capq[$];
  logic [PW-1:0] expq[$];
  logic exp_step = 1'b0;
  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign thr_ref   = d_ref[thr_sel];
  assign thr_wr    = d_wr[thr_sel];
  assign thr_mod   = d_mod[thr_sel];
  assign thr_addr  = d_addr[thr_sel];
  assign thr_wdata = d_wd[thr_sel];

  vp_injector #(.NTHR(NT), .MOD_W(MW), .ADDR_W(AW), .DATA_W(DW), .MAX_INFLIGHT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .thr_sel(thr_sel),
    .thr_ref(thr_ref), .thr_wr(thr_wr), .thr_mod(thr_mod), .thr_addr(thr_addr),
    .thr_wdata(thr_wdata), .pkt_valid(pkt_valid), .pkt_kind(pkt_kind),
    .pkt_thread(pkt_thread), .pkt_mod(pkt_mod), .pkt_addr(pkt_addr),
    .pkt_data(pkt_data), .pkt_step(pkt_step), .rsp_valid(rsp_valid),
    .rsp_eor(rsp_eor), .rsp_thread(rsp_thread), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  function automatic logic [PW-1:0] pack(input logic [1:0] k, input logic [TW-1:0] t,
      input logic [MW-1:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s);
    return {k, t, m, a, d, s};
  endfunction

  always @(negedge clk)
    if (rst_n && pkt_valid)
      capq.push_back(pack(pkt_kind, pkt_thread, pkt_mod, pkt_addr, pkt_data, pkt_step));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic plan_step();
    for (int i = 0; i < NT; i++)
      if (d_ref[i])
        expq.push_back(pack(d_wr[i] ? 2'd1 : 2'd0, TW'(i), d_mod[i], d_addr[i],
                            d_wr[i] ? d_wd[i] : '0, exp_step));
    expq.push_back(pack(2'd2, '0, '0, '0, '0, exp_step));
    exp_step = ~exp_step;
  endtask

  task automatic compare(input string req);
    chk(capq.size() == expq.size(), {req, " packet count"}, 64'(capq.size()), 64'(expq.size()));
    for (int i = 0; i < capq.size() && i < expq.size(); i++)
      chk(capq[i] == expq[i], {req, " packet"}, 64'(capq[i]), 64'(expq[i]));
    capq.delete();
    expq.delete();
  endtask

  task automatic rand_desc();
    for (int i = 0; i < NT; i++) begin
      d_ref[i]  = 1'($urandom_range(0, 1));
      d_wr[i]   = 1'($urandom_range(0, 1));
      d_mod[i]  = MW'($urandom);
      d_addr[i] = AW'($urandom);
      d_wd[i]   = DW'($urandom);
    end
  endtask

  task automatic pulse_run();
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
    repeat (NT + 4) @(negedge clk);
  endtask

  task automatic send_rsp(input logic eor, input logic [TW-1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_eor = eor; rsp_thread = t; rsp_data = d;
    chk(rsp_ready == 1'b1, "R8 rsp_ready", 64'(rsp_ready), 64'd1);
    if (!eor) exp_reg[t] = d;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_eor = 1'b0;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NT; i++) begin
      rd_sel = TW'(i);
      #0.5;
      chk(rd_data == exp_reg[i], req, 64'(rd_data), 64'(exp_reg[i]));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < NT; i++) begin
      d_ref[i] = 0; d_wr[i] = 0; d_mod[i] = '0; d_addr[i] = '0; d_wd[i] = '0; exp_reg[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pkt_valid == 1'b0, "R1 pkt_valid", 64'(pkt_valid), 64'd0);
    chk(rsp_ready == 1'b1, "R1 rsp_ready", 64'(rsp_ready), 64'd1);
    check_regs("R1 reset register");

    // R10 stray end-of-replies with nothing open
    send_rsp(1'b1, '0, 16'hdead);

    // R3 step without any reference: only the end-of-stream
    plan_step();
    pulse_run();
    compare("R3 empty step");

    // R2 every thread references, reads and writes mixed
    for (int i = 0; i < NT; i++) begin
      d_ref[i] = 1; d_wr[i] = (i % 2 == 1); d_mod[i] = MW'(i + 3);
      d_addr[i] = AW'(8'h40 + i); d_wd[i] = DW'(16'hA000 + i);
    end
    plan_step();
    pulse_run();
    compare("R2 R4 full step");

    // R5 R10 two steps open: a held run must not start a third
    rand_desc();
    d_ref[NT-1] = 1;
    @(negedge clk) run = 1'b1;
    repeat (20) @(negedge clk);
    chk(capq.size() == 0, "R5 R10 third step blocked", 64'(capq.size()), 64'd0);
    plan_step();
    send_rsp(1'b1, '0, '0);
    repeat (20) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    compare("R5 one step per credit");

    // R7 end-of-replies leaves registers alone
    send_rsp(1'b1, 2'd1, 16'hbeef);
    send_rsp(1'b1, 2'd2, 16'hcafe);
    check_regs("R7 eor no write");

    // R9 run low: nothing starts
    repeat (20) @(negedge clk);
    chk(capq.size() == 0, "R9 idle without run", 64'(capq.size()), 64'd0);

    // R6 directed replies, last thread and first thread
    send_rsp(1'b0, TW'(NT - 1), 16'hffff);
    send_rsp(1'b0, '0, 16'h0001);
    check_regs("R6 reply write");

    // random steps and replies
    for (int it = 0; it < 20; it++) begin
      rand_desc();
      plan_step();
      pulse_run();
      compare("R2 R3 R4 R9 random step");
      send_rsp(1'b1, '0, '0);
      for (int r = 0; r < 3; r++)
        send_rsp(1'b0, TW'($urandom_range(0, NT - 1)), DW'($urandom));
      check_regs("R6 random reply");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule